// File: doc/BRIEF.md
# Two-Stage Dual-Clock FIFO with Shallow Crossing Buffer

This block is a first-in first-out queue that carries words from a write clock domain into an independent read clock domain. Storage is split across two stages. The first stage is a large main store that sits entirely inside the write clock. It accepts words on the rising write clock edge and gives them up on the falling edge, so its two sides can never act at the same instant. The second stage is a small buffer that does the real clock crossing. It uses Gray-coded pointers, and each pointer passes through a two-flop synchroniser into the other domain. On every falling write clock edge, a transfer controller moves one word from the main store into the buffer, provided the main store holds data and the buffer, as seen from the write side, has room.

This arrangement suits the case where the write clock is the faster of the two, or where neither clock is known to be faster. The user stops writing when `almostFull` rises. The user keeps reading until `empty` rises. The `almostEmpty` warning is approximate: it can lag `empty`, and handshake delay can move its threshold by a few words.

Top module: `cdc_chain_fifo`

## Requirements
- R1: While either reset is low, and after both resets are released with no write, `empty`=1, `almostEmpty`=1, `almostFull`=0, `wrErr`=0 and `rdErr`=0. A reset taken mid-stream discards every stored word.
- R2: Words leave at `rdData` in the order in which they were accepted. This holds for isolated bursts and also when writes and reads run at the same time.
- R3: Without reads, the block accepts MAIN_DEPTH+BUF_DEPTH words (80 by default). A write made while the main store is full is dropped, and `wrErr` is 1 for exactly the write clock cycle that follows that edge.
- R4: A read requested while `empty`=1 is ignored and leaves `rdData` unchanged. `rdErr` is 1 for the read clock cycle that follows that edge.
- R5: After a word is written into an empty block, `empty` falls within 4 read clock cycles.
- R6: `almostFull` is 1 exactly when the main store holds at least MAIN_DEPTH-AF_OFFSET words. With no reads, that means at least BUF_DEPTH+MAIN_DEPTH-AF_OFFSET accepted words (72 by default).
- R7: Once settled, `almostEmpty` is 1 when the buffer holds at most AE_OFFSET words and the main store, as seen from the read side, is empty. It is 0 when the buffer holds more than AE_OFFSET words.
- R8: A word moves from the main store into the buffer only on a falling write clock edge, and only when the main store is non-empty and the write-side view of buffer occupancy is below BUF_DEPTH.
- R9: Each Gray pointer of the buffer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock. Rising edge writes the main store; falling edge drives transfers. |
| wrRstN | input | 1 | Active-low asynchronous reset of the write domain. |
| wrEn | input | 1 | Write request. |
| wrData | input | DATA_W | Word to write. |
| almostFull | output | 1 | Stop-writing indication. |
| wrErr | output | 1 | Pulses after a dropped write. |
| rdClk | input | 1 | Read clock. |
| rdRstN | input | 1 | Active-low asynchronous reset of the read domain. |
| rdEn | input | 1 | Read request. |
| rdData | output | DATA_W | Word read; registered and held between reads. |
| empty | output | 1 | No word available to the read side. |
| almostEmpty | output | 1 | Approximate low-fill warning. |
| rdErr | output | 1 | Pulses after an ignored read. |

## Verification
Each result has its own timing, and every check is taken 1 ns after the edge that produces the result.

- `wrErr` and `almostFull` change on the rising write edge that accepts or drops a word. They are sampled before the following falling edge.
- `rdData` and `rdErr` are registered on the read edge that carries the request. They are checked right after that edge.
- `empty` passes through the two-stage pointer synchroniser. The bench counts read edges after a write and expects the fall within a four-cycle window.
- `almostEmpty` is only compared after several read cycles of settling.

// File: rtl/cdcf_pkg.sv
package cdcf_pkg;

  // Strobes from the control module to the storage datapath
  typedef struct packed {
    logic mainPush;  // write wrData into main store (rising wrClk)
    logic xferMove;  // main store head into buffer (falling wrClk)
    logic bufPop;    // buffer head into rdData (rising rdClk)
  } cdcfStrobes_t;

endpackage

// File: rtl/cdcf_datapath.sv
module cdcf_datapath
  import cdcf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAIN_DEPTH = 64,
  parameter int BUF_DEPTH  = 16,
  localparam int MAIN_AW   = $clog2(MAIN_DEPTH),
  localparam int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic               wrClk,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  cdcfStrobes_t       stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [MAIN_AW-1:0] mainWrAddr,
  input  logic [MAIN_AW-1:0] mainRdAddr,
  input  logic [BUF_AW-1:0]  bufWrAddr,
  input  logic [BUF_AW-1:0]  bufRdAddr,
  output logic [DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] mainMem [MAIN_DEPTH];
  logic [DATA_W-1:0] bufMem  [BUF_DEPTH];

  // Main store write port: true write clock
  always_ff @(posedge wrClk) begin
    if (stb.mainPush) mainMem[mainWrAddr] <= wrData;
  end

  // Main store read port and buffer write port: inverted write clock
  always_ff @(negedge wrClk) begin
    if (stb.xferMove) bufMem[bufWrAddr] <= mainMem[mainRdAddr];
  end

  // Buffer read port: read clock, registered output
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdData <= '0;
    else if (stb.bufPop) rdData <= bufMem[bufRdAddr];
  end

endmodule

// File: rtl/cdcf_control.sv
module cdcf_control
  import cdcf_pkg::*;
#(
  parameter int MAIN_DEPTH = 64,
  parameter int BUF_DEPTH  = 16,
  parameter int AF_OFFSET  = 8,
  parameter int AE_OFFSET  = 4,
  localparam int MAIN_AW   = $clog2(MAIN_DEPTH),
  localparam int BUF_AW    = $clog2(BUF_DEPTH),
  localparam int MPW       = MAIN_AW + 1,
  localparam int BPW       = BUF_AW + 1
) (
  input  logic               wrClk,
  input  logic               wrRstN,
  input  logic               wrEn,
  output logic               almostFull,
  output logic               wrErr,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  logic               rdEn,
  output logic               empty,
  output logic               almostEmpty,
  output logic               rdErr,
  output cdcfStrobes_t       stb,
  output logic [MAIN_AW-1:0] mainWrAddr,
  output logic [MAIN_AW-1:0] mainRdAddr,
  output logic [BUF_AW-1:0]  bufWrAddr,
  output logic [BUF_AW-1:0]  bufRdAddr
);

  localparam logic [MPW-1:0] MAIN_FULL_LVL = MPW'(MAIN_DEPTH);
  localparam logic [MPW-1:0] MAIN_AF_LVL   = MPW'(MAIN_DEPTH - AF_OFFSET);
  localparam logic [BPW-1:0] BUF_FULL_LVL  = BPW'(BUF_DEPTH);
  localparam logic [BPW-1:0] BUF_AE_LVL    = BPW'(AE_OFFSET);

  function automatic logic [BPW-1:0] gray2bin(input logic [BPW-1:0] g);
    logic [BPW-1:0] b;
    b[BPW-1] = g[BPW-1];
    for (int i = BPW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [BPW-1:0] bin2gray(input logic [BPW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- write domain, rising edge ----------------
  logic [MPW-1:0] mainWrPtr;
  logic [MPW-1:0] mainRdPtr;
  logic [MPW-1:0] mainCount;
  logic           mainFull;
  logic           mainPush;
  logic           wrErrQ;

  assign mainCount  = mainWrPtr - mainRdPtr;
  assign mainFull   = (mainCount == MAIN_FULL_LVL);
  assign mainPush   = wrEn && !mainFull;
  assign almostFull = (mainCount >= MAIN_AF_LVL);
  assign wrErr      = wrErrQ;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      mainWrPtr <= '0;
      wrErrQ    <= 1'b0;
    end else begin
      if (mainPush) mainWrPtr <= mainWrPtr + MPW'(1);
      wrErrQ <= wrEn && mainFull;
    end
  end

  // ---------------- write domain, falling edge (transfer engine) ----------------
  logic [BPW-1:0] bufWrBin;
  logic [BPW-1:0] bufWrGray;
  logic [BPW-1:0] rdGrayS1;
  logic [BPW-1:0] rdGrayS2;
  logic [BPW-1:0] rdBinSeenW;
  logic [BPW-1:0] bufUsedW;
  logic           mainEmpty;
  logic           bufFullW;
  logic           xferMove;
  logic           mainEmptyQ;

  assign mainEmpty  = (mainCount == '0);
  assign rdBinSeenW = gray2bin(rdGrayS2);
  assign bufUsedW   = bufWrBin - rdBinSeenW;
  assign bufFullW   = (bufUsedW == BUF_FULL_LVL);
  assign xferMove   = !mainEmpty && !bufFullW;

  always_ff @(negedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      mainRdPtr  <= '0;
      bufWrBin   <= '0;
      bufWrGray  <= '0;
      rdGrayS1   <= '0;
      rdGrayS2   <= '0;
      mainEmptyQ <= 1'b1;
    end else begin
      rdGrayS1 <= bufRdGray;
      rdGrayS2 <= rdGrayS1;
      if (xferMove) begin
        mainRdPtr <= mainRdPtr + MPW'(1);
        bufWrBin  <= bufWrBin + BPW'(1);
        bufWrGray <= bin2gray(bufWrBin + BPW'(1));
      end
      mainEmptyQ <= (mainWrPtr == (mainRdPtr + MPW'(xferMove)));
    end
  end

  // ---------------- read domain ----------------
  logic [BPW-1:0] bufRdBin;
  logic [BPW-1:0] bufRdGray;
  logic [BPW-1:0] wrGrayS1;
  logic [BPW-1:0] wrGrayS2;
  logic [BPW-1:0] bufFillR;
  logic           mainEmptyS1;
  logic           mainEmptyS2;
  logic           bufPop;
  logic           rdErrQ;

  assign empty       = (bufRdGray == wrGrayS2);
  assign bufPop      = rdEn && !empty;
  assign bufFillR    = gray2bin(wrGrayS2) - bufRdBin;
  assign almostEmpty = mainEmptyS2 && (bufFillR <= BUF_AE_LVL);
  assign rdErr       = rdErrQ;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      bufRdBin    <= '0;
      bufRdGray   <= '0;
      wrGrayS1    <= '0;
      wrGrayS2    <= '0;
      mainEmptyS1 <= 1'b1;
      mainEmptyS2 <= 1'b1;
      rdErrQ      <= 1'b0;
    end else begin
      wrGrayS1    <= bufWrGray;
      wrGrayS2    <= wrGrayS1;
      mainEmptyS1 <= mainEmptyQ;
      mainEmptyS2 <= mainEmptyS1;
      rdErrQ      <= rdEn && empty;
      if (bufPop) begin
        bufRdBin  <= bufRdBin + BPW'(1);
        bufRdGray <= bin2gray(bufRdBin + BPW'(1));
      end
    end
  end

  // ---------------- strobes and addresses to datapath ----------------
  assign stb.mainPush = mainPush;
  assign stb.xferMove = xferMove;
  assign stb.bufPop   = bufPop;
  assign mainWrAddr   = mainWrPtr[MAIN_AW-1:0];
  assign mainRdAddr   = mainRdPtr[MAIN_AW-1:0];
  assign bufWrAddr    = bufWrBin[BUF_AW-1:0];
  assign bufRdAddr    = bufRdBin[BUF_AW-1:0];

  // ---------------- assertions ----------------
  a_r3_main_bounded: assert property (@(posedge wrClk) disable iff (!wrRstN)
    mainCount <= MAIN_FULL_LVL);

  a_r3_full_write_dropped: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && mainFull) |=> (mainWrPtr == $past(mainWrPtr)));

  a_r8_buffer_bounded: assert property (@(negedge wrClk) disable iff (!wrRstN)
    bufUsedW <= BUF_FULL_LVL);

  a_r8_move_needs_data: assert property (@(negedge wrClk) disable iff (!wrRstN)
    (mainWrPtr == mainRdPtr) |=> (mainRdPtr == $past(mainRdPtr)));

  a_r9_wr_gray_step: assert property (@(negedge wrClk) disable iff (!wrRstN)
    $countones(bufWrGray ^ $past(bufWrGray)) <= 1);

  a_r9_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(bufRdGray ^ $past(bufRdGray)) <= 1);

  a_r4_no_pop_when_empty: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (empty && rdEn) |=> (bufRdBin == $past(bufRdBin)));

  a_r7_empty_implies_low: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (empty && mainEmptyS2) |-> almostEmpty);

endmodule

// File: rtl/cdc_chain_fifo.sv
module cdc_chain_fifo
  import cdcf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAIN_DEPTH = 64,
  parameter int BUF_DEPTH  = 16,
  parameter int AF_OFFSET  = 8,
  parameter int AE_OFFSET  = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              almostFull,
  output logic              wrErr,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  output logic              rdErr
);

  localparam int MAIN_AW = $clog2(MAIN_DEPTH);
  localparam int BUF_AW  = $clog2(BUF_DEPTH);

  cdcfStrobes_t       stb;
  logic [MAIN_AW-1:0] mainWrAddr;
  logic [MAIN_AW-1:0] mainRdAddr;
  logic [BUF_AW-1:0]  bufWrAddr;
  logic [BUF_AW-1:0]  bufRdAddr;

  cdcf_control #(
    .MAIN_DEPTH(MAIN_DEPTH), .BUF_DEPTH(BUF_DEPTH),
    .AF_OFFSET(AF_OFFSET),   .AE_OFFSET(AE_OFFSET)
  ) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn),
    .almostFull(almostFull), .wrErr(wrErr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .empty(empty), .almostEmpty(almostEmpty), .rdErr(rdErr),
    .stb(stb),
    .mainWrAddr(mainWrAddr), .mainRdAddr(mainRdAddr),
    .bufWrAddr(bufWrAddr),   .bufRdAddr(bufRdAddr)
  );

  cdcf_datapath #(
    .DATA_W(DATA_W), .MAIN_DEPTH(MAIN_DEPTH), .BUF_DEPTH(BUF_DEPTH)
  ) uPath (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN),
    .stb(stb), .wrData(wrData),
    .mainWrAddr(mainWrAddr), .mainRdAddr(mainRdAddr),
    .bufWrAddr(bufWrAddr),   .bufRdAddr(bufRdAddr),
    .rdData(rdData)
  );

endmodule

// File: tb/tb_cdc_chain_fifo.sv
`timescale 1ns/100ps
module tb_cdc_chain_fifo;

  localparam int DATA_W = 16;
  localparam int CAP    = 80;   // 64 main + 16 buffer
  localparam int AF_AT  = 72;   // 16 + 64 - 8
  localparam int NVEC   = 6;
  // {burst length, base value}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0001_1000, 32'h0002_2100, 32'h0005_3200,
    32'h0010_4300, 32'h0011_5400, 32'h001E_6500
  };

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic wrEn = 0, rdEn = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic almostFull, wrErr, empty, almostEmpty, rdErr;

  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  initial begin #1.3; forever #5 rdClk = ~rdClk; end

  cdc_chain_fifo dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .almostFull(almostFull), .wrErr(wrErr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .empty(empty), .almostEmpty(almostEmpty), .rdErr(rdErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [DATA_W-1:0] d);
    wrEn = 1; wrData = d;
    @(posedge wrClk); #1;
    wrEn = 0;
  endtask

  task automatic read_word(input logic [DATA_W-1:0] exp, input string req);
    int guard = 0;
    while (empty && guard < 50) begin @(posedge rdClk); #1; guard++; end
    rdEn = 1;
    @(posedge rdClk); #1;
    rdEn = 0;
    chk(rdData == exp, req, "read data", rdData, exp);
  endtask

  task automatic settle_rd(input int n);
    repeat (n) @(posedge rdClk);
    #1;
  endtask

  task automatic do_reset();
    wrRstN = 0; rdRstN = 0;
    repeat (3) @(posedge rdClk);
    #1;
    chk(empty && almostEmpty && !almostFull && !wrErr && !rdErr, "R1",
        "flags in reset", {empty, almostEmpty, almostFull, wrErr, rdErr}, 5'b11000);
    wrRstN = 1; rdRstN = 1;
    settle_rd(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #300000;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: state after release
    chk(empty && almostEmpty && !almostFull && !wrErr && !rdErr, "R1",
        "flags after reset", {empty, almostEmpty, almostFull, wrErr, rdErr}, 5'b11000);

    // R2: table of bursts, each written then read back in order
    for (int v = 0; v < NVEC; v++) begin
      int len = int'(VEC[v][31:16]);
      logic [DATA_W-1:0] base = VEC[v][15:0];
      @(posedge wrClk); #1;
      for (int i = 0; i < len; i++) write_word(base + DATA_W'(i));
      for (int i = 0; i < len; i++) read_word(base + DATA_W'(i), "R2");
      settle_rd(2);
      chk(empty == 1'b1, "R2", "empty after burst drained", empty, 1);
    end

    // R5: empty latency after a single write
    begin
      int waitCyc = 0;
      @(posedge wrClk); #1;
      write_word(16'hA5A5);
      @(posedge rdClk); #1;
      waitCyc = 1;
      while (empty && waitCyc < 10) begin @(posedge rdClk); #1; waitCyc++; end
      chk(waitCyc <= 4, "R5", "read cycles until not empty", waitCyc, 4);
      read_word(16'hA5A5, "R5");
    end

    // R4: read while empty
    settle_rd(3);
    rdEn = 1;
    @(posedge rdClk); #1;
    rdEn = 0;
    chk(rdErr == 1'b1, "R4", "rdErr after empty read", rdErr, 1);
    chk(rdData == 16'hA5A5, "R4", "rdData held", rdData, 16'hA5A5);
    @(posedge rdClk); #1;
    chk(rdErr == 1'b0, "R4", "rdErr single cycle", rdErr, 0);

    // R7: almost-empty threshold
    @(posedge wrClk); #1;
    for (int i = 0; i < 3; i++) write_word(16'h7000 + DATA_W'(i));
    settle_rd(8);
    chk(!empty && almostEmpty, "R7", "3 words: not empty, low", {empty, almostEmpty}, 2'b01);
    @(posedge wrClk); #1;
    for (int i = 3; i < 8; i++) write_word(16'h7000 + DATA_W'(i));
    settle_rd(8);
    chk(almostEmpty == 1'b0, "R7", "8 words: not low", almostEmpty, 0);
    for (int i = 0; i < 8; i++) read_word(16'h7000 + DATA_W'(i), "R7");

    // R6 / R3: fill without reads
    settle_rd(4);
    @(posedge wrClk); #1;
    for (int i = 0; i < AF_AT - 1; i++) write_word(16'h8000 + DATA_W'(i));
    chk(almostFull == 1'b0, "R6", "almostFull one below threshold", almostFull, 0);
    write_word(16'h8000 + DATA_W'(AF_AT - 1));
    chk(almostFull == 1'b1, "R6", "almostFull at threshold", almostFull, 1);
    for (int i = AF_AT; i < CAP; i++) write_word(16'h8000 + DATA_W'(i));
    chk(wrErr == 1'b0, "R3", "no error at capacity", wrErr, 0);
    write_word(16'hDEAD);
    chk(wrErr == 1'b1, "R3", "wrErr after overflow write", wrErr, 1);
    @(posedge wrClk); #1;
    chk(wrErr == 1'b0, "R3", "wrErr single cycle", wrErr, 0);
    for (int i = 0; i < CAP; i++) read_word(16'h8000 + DATA_W'(i), "R3");
    settle_rd(3);
    chk(empty == 1'b1, "R3", "empty after capacity drained (overflow word dropped)", empty, 1);
    chk(almostFull == 1'b0, "R6", "almostFull cleared after drain", almostFull, 0);

    // R2: concurrent writing and reading
    fork
      begin
        @(posedge wrClk); #1;
        for (int i = 0; i < 40; i++) begin
          while (almostFull) begin @(posedge wrClk); #1; end
          write_word(16'h9000 + DATA_W'(i));
        end
      end
      begin
        for (int i = 0; i < 40; i++) read_word(16'h9000 + DATA_W'(i), "R2");
      end
    join

    // R1: reset mid-stream discards contents
    @(posedge wrClk); #1;
    for (int i = 0; i < 5; i++) write_word(16'hB000 + DATA_W'(i));
    settle_rd(6);
    do_reset();
    settle_rd(4);
    chk(empty && almostEmpty && !almostFull, "R1", "flags after mid-stream reset",
        {empty, almostEmpty, almostFull}, 3'b110);

    finish_run();
  end

endmodule